// File: doc/BRIEF.md
# Watchdog Timer with Shared Assignable Prescaler

This block is a watchdog that runs from its own free-running oscillator clock, so it keeps counting while the main core clock is stopped for sleep. A base counter wraps every `BASE_TICKS` watchdog cycles. Each wrap is a base event. When the watchdog ends a period, it raises a one-cycle reset request if the core is awake. If the core is asleep, it raises a one-cycle wake-up request instead. It also drives an active-low time-out status flag to 0.

There is one 8-stage prescaler. A select bit in a small option register assigns it either to the watchdog or to an external timer tick path. When the prescaler is assigned to the watchdog, it divides the base events by 1 to 128. When it is assigned to the timer, it divides the incoming timer ticks by 2 to 256, and the watchdog runs undivided. A 3-bit ratio field picks the division ratio through a tap multiplexer.

Core software controls the watchdog through three strobes:
- a clear strobe, which restarts the watchdog;
- a sleep strobe, which also restarts it;
- an option write, which loads the select bit and the ratio field.

A static configuration input disables the watchdog completely.

Top module: `wdog_presc_top`

## Requirements
- R1: With the select bit at 0, the watchdog times out every `BASE_TICKS` cycles. The first request pulse is visible exactly `BASE_TICKS` cycles after the edge that restarted it.
- R2: With the select bit at 1 and ratio code c (0 to 7), the time-out period is `BASE_TICKS * 2^c` cycles, measured from the restarting edge.
- R3: After reset, the option register holds select = 1 and ratio code = 7 (divide by 128). The first time-out follows `BASE_TICKS * 128` cycles after reset is released.
- R4: A time-out while `core_asleep` is 0 gives a reset-request pulse only. A time-out while `core_asleep` is 1 gives a wake-request pulse only. The two requests are never high together.
- R5: A clear strobe restarts the base counter. When the prescaler is assigned to the watchdog, the strobe also clears the prescaler. No request follows in the cycle after the strobe.
- R6: A sleep strobe restarts the watchdog in the same way as a clear strobe.
- R7: `to_flag_n` is 1 after reset. It goes to 0 in the cycle of any request pulse. It returns to 1 after a clear or sleep strobe.
- R8: While `cfg_wd_en` is 0, no request pulses are produced and `to_flag_n` does not change.
- R9: With the select bit at 0 and ratio code c, `tmr_tick_out` pulses once per `2^(c+1)` source ticks, starting from a cleared prescaler, one cycle after the source tick. With the select bit at 1, `tmr_tick_out` is `tmr_src_tick` delayed by one cycle.
- R10: An option write that changes the select bit clears the prescaler and the base counter. The next time-out is then a full period after the write edge.
- R11: Every reset-request and wake-request pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running watchdog oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wd_en | input | 1 | Static configuration enable; 0 disables the watchdog |
| core_asleep | input | 1 | 1 while the core is in sleep |
| clr_stb | input | 1 | Clear-watchdog strobe |
| sleep_stb | input | 1 | Sleep-command strobe |
| opt_we | input | 1 | Option register write strobe |
| opt_sel_in | input | 1 | Write data: 1 assigns the prescaler to the watchdog, 0 assigns it to the timer |
| opt_ratio_in | input | 3 | Write data: prescaler ratio code |
| tmr_src_tick | input | 1 | External timer source tick |
| tmr_tick_out | output | 1 | Timer tick, prescaled or passed through |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| to_flag_n | output | 1 | Time-out status; 0 after a time-out |

## Verification
The assertions assume the following about the inputs:
- strobes and option writes are sampled on `clk` edges;
- `core_asleep` is stable in the cycle that ends a period, because the request check looks back one cycle at it;
- `cfg_wd_en` is treated as static.

The stimulus respects these limits:
- it drives every input at the falling edge;
- it holds each strobe for a single cycle;
- it changes `core_asleep` only together with a sleep strobe or well away from a period end;
- it toggles the enable only around dedicated quiet windows that are bracketed by clear strobes.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
   typedef enum logic {
      ASSIGN_TMR = 1'b0,
      ASSIGN_WDT = 1'b1
   } assign_e;

   typedef struct packed {
      assign_e    owner;
      logic [2:0] ratio;
   } opt_t;
endpackage

// File: rtl/wdp_base_counter.sv
module wdp_base_counter #(
   parameter int BASE_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic restart,
   output logic base_ev
);
   localparam int CW = (BASE_TICKS > 1) ? $clog2(BASE_TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(BASE_TICKS - 1);

   logic [CW-1:0] cnt_q;

   assign base_ev = en && !restart && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || !en) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdp_prescaler.sv
module wdp_prescaler #(
   parameter int STAGES = 8,
   parameter int SEL_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             in_ev,
   input  logic [SEL_W-1:0] sel,
   output logic             out_ev
);
   localparam int TAPS = 1 << SEL_W;

   logic [STAGES-1:0] cnt_q;
   logic [TAPS-1:0]   full;

   // full[k] is 1 when the low k stages are all ones (the next event completes 2^k)
   assign full[0] = 1'b1;
   for (genvar k = 1; k < TAPS; k++) begin : g_tap
      if (k <= STAGES) begin : g_real
         assign full[k] = full[k-1] & cnt_q[k-1];
      end else begin : g_unused
         assign full[k] = 1'b0;
      end
   end

   assign out_ev = in_ev && !clr && full[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (in_ev) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdp_event_out.sv
module wdp_event_out (
   input  logic clk,
   input  logic rst_n,
   input  logic timeout,
   input  logic asleep,
   input  logic restart,
   output logic rst_req,
   output logic wake_req,
   output logic to_flag_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req   <= 1'b0;
         wake_req  <= 1'b0;
         to_flag_n <= 1'b1;
      end else begin
         rst_req  <= timeout && !asleep;
         wake_req <= timeout && asleep;
         if (restart) begin
            to_flag_n <= 1'b1;
         end else if (timeout) begin
            to_flag_n <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/wdog_presc_top.sv
module wdog_presc_top #(
   parameter int BASE_TICKS = 16,
   parameter int RATIO_W    = 3,
   parameter int STAGES     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wd_en,
   input  logic               core_asleep,
   input  logic               clr_stb,
   input  logic               sleep_stb,
   input  logic               opt_we,
   input  logic               opt_sel_in,
   input  logic [RATIO_W-1:0] opt_ratio_in,
   input  logic               tmr_src_tick,
   output logic               tmr_tick_out,
   output logic               rst_req,
   output logic               wake_req,
   output logic               to_flag_n
);
   import wdp_pkg::*;

   localparam int SEL_W = RATIO_W + 1;

   if (BASE_TICKS < 2) begin : g_bad_base
      $error("BASE_TICKS must be at least 2");
   end
   if (STAGES != (1 << RATIO_W)) begin : g_bad_stages
      $error("STAGES must equal 2**RATIO_W");
   end
   if (RATIO_W != 3) begin : g_bad_ratio
      $error("option register layout assumes a 3-bit ratio field");
   end

   opt_t opt_q;
   logic sel_change, cmd_restart, wd_restart, pre_clr;
   logic base_ev, pre_in, pre_out, timeout;
   logic [SEL_W-1:0] tap_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opt_q <= '{owner: ASSIGN_WDT, ratio: '1};
      end else if (opt_we) begin
         opt_q <= '{owner: assign_e'(opt_sel_in), ratio: opt_ratio_in};
      end
   end

   assign sel_change  = opt_we && (assign_e'(opt_sel_in) != opt_q.owner);
   assign cmd_restart = clr_stb || sleep_stb;
   assign wd_restart  = cmd_restart || sel_change;
   assign pre_clr     = sel_change || ((opt_q.owner == ASSIGN_WDT) && cmd_restart);

   wdp_base_counter #(.BASE_TICKS(BASE_TICKS)) base_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cfg_wd_en),
      .restart (wd_restart),
      .base_ev (base_ev)
   );

   assign pre_in  = (opt_q.owner == ASSIGN_WDT) ? base_ev : tmr_src_tick;
   assign tap_sel = (opt_q.owner == ASSIGN_WDT) ? {1'b0, opt_q.ratio}
                                                : ({1'b0, opt_q.ratio} + 1'b1);

   wdp_prescaler #(.STAGES(STAGES), .SEL_W(SEL_W)) pre_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (pre_clr),
      .in_ev  (pre_in),
      .sel    (tap_sel),
      .out_ev (pre_out)
   );

   assign timeout = cfg_wd_en && !wd_restart &&
                    ((opt_q.owner == ASSIGN_WDT) ? pre_out : base_ev);

   wdp_event_out evt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .timeout   (timeout),
      .asleep    (core_asleep),
      .restart   (cmd_restart),
      .rst_req   (rst_req),
      .wake_req  (wake_req),
      .to_flag_n (to_flag_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_tick_out <= 1'b0;
      end else begin
         tmr_tick_out <= (opt_q.owner == ASSIGN_WDT) ? tmr_src_tick : pre_out;
      end
   end
endmodule

// File: rtl/wdp_checker.sv
module wdp_checker (
   input logic clk,
   input logic rst_n,
   input logic cfg_wd_en,
   input logic core_asleep,
   input logic clr_stb,
   input logic sleep_stb,
   input logic rst_req,
   input logic wake_req,
   input logic to_flag_n
);
   p_req_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_req && wake_req));

   p_rst_when_awake_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(!core_asleep));

   p_wake_when_asleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> $past(core_asleep));

   p_clear_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> (!rst_req && !wake_req));

   p_sleep_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_stb |=> (!rst_req && !wake_req && to_flag_n));

   p_flag_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req || wake_req) |-> !to_flag_n);

   p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> to_flag_n);

   p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wd_en |=> (!rst_req && !wake_req));

   p_rst_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   p_wake_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> !wake_req);
endmodule

bind wdog_presc_top wdp_checker chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_wd_en   (cfg_wd_en),
   .core_asleep (core_asleep),
   .clr_stb     (clr_stb),
   .sleep_stb   (sleep_stb),
   .rst_req     (rst_req),
   .wake_req    (wake_req),
   .to_flag_n   (to_flag_n)
);

// File: tb/wdog_presc_top_tb_top.sv
`timescale 1ns/1ps
module wdog_presc_top_tb_top;
   localparam int BASE = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wd_en = 1'b1;
   logic core_asleep = 1'b0;
   logic clr_stb = 1'b0;
   logic sleep_stb = 1'b0;
   logic opt_we = 1'b0;
   logic opt_sel_in = 1'b1;
   logic [2:0] opt_ratio_in = 3'd7;
   logic tmr_src_tick = 1'b0;
   logic tmr_tick_out, rst_req, wake_req, to_flag_n;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdog_presc_top #(.BASE_TICKS(BASE)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wd_en(cfg_wd_en), .core_asleep(core_asleep),
      .clr_stb(clr_stb), .sleep_stb(sleep_stb), .opt_we(opt_we),
      .opt_sel_in(opt_sel_in), .opt_ratio_in(opt_ratio_in),
      .tmr_src_tick(tmr_src_tick), .tmr_tick_out(tmr_tick_out),
      .rst_req(rst_req), .wake_req(wake_req), .to_flag_n(to_flag_n)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr_stb = 1'b1;
      @(posedge clk); #1 clr_stb = 1'b0;
   endtask

   task automatic wr_opt(input bit sel, input logic [2:0] ratio);
      @(negedge clk); opt_we = 1'b1; opt_sel_in = sel; opt_ratio_in = ratio;
      @(posedge clk); #1 opt_we = 1'b0;
   endtask

   // counts edges from the last strobe edge until a request is seen
   task automatic measure(output int n, output bit was_rst, output bit was_wake);
      n = 0; was_rst = 0; was_wake = 0;
      while (n < 5000) begin
         @(posedge clk); n++; #1;
         if (rst_req || wake_req) begin
            was_rst = rst_req; was_wake = wake_req;
            break;
         end
      end
   endtask

   task automatic t_reset_default();
      int n; bit r, w;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk(rst_req == 0 && wake_req == 0, "R4 reset outputs low", rst_req + wake_req, 0);
      chk(to_flag_n == 1, "R7 reset flag", to_flag_n, 1);
      @(negedge clk); rst_n = 1'b1;
      measure(n, r, w);
      chk(n == BASE * 128, "R3 default period", n, BASE * 128);
      chk(r == 1 && w == 0, "R4 awake reset request", r, 1);
      chk(to_flag_n == 0, "R7 flag after timeout", to_flag_n, 0);
      @(posedge clk); #1;
      chk(rst_req == 0, "R11 single pulse", rst_req, 0);
   endtask

   task automatic t_ratio(input logic [2:0] c);
      int n; bit r, w;
      wr_opt(1'b1, c);
      pulse_clr();
      chk(to_flag_n == 1, "R7 flag set by clear", to_flag_n, 1);
      measure(n, r, w);
      chk(n == (BASE << c), $sformatf("R2 period code %0d", c), n, BASE << c);
   endtask

   task automatic t_undivided();
      int n; bit r, w;
      wr_opt(1'b0, 3'd5);
      pulse_clr();
      measure(n, r, w);
      chk(n == BASE, "R1 undivided period", n, BASE);
      measure(n, r, w);
      chk(n == BASE, "R1 undivided repeat", n, BASE);
   endtask

   task automatic t_clear_restart();
      int n; bit r, w;
      wr_opt(1'b1, 3'd2);
      pulse_clr();
      repeat (40) @(posedge clk);
      pulse_clr();
      measure(n, r, w);
      chk(n == BASE * 4, "R5 clear restarts", n, BASE * 4);
   endtask

   task automatic t_sleep_wake();
      int n; bit r, w;
      wr_opt(1'b1, 3'd1);
      pulse_clr();
      repeat (10) @(posedge clk);
      @(negedge clk); sleep_stb = 1'b1; core_asleep = 1'b1;
      @(posedge clk); #1 sleep_stb = 1'b0;
      chk(to_flag_n == 1, "R6 flag after sleep", to_flag_n, 1);
      measure(n, r, w);
      chk(n == BASE * 2, "R6 sleep restarts", n, BASE * 2);
      chk(w == 1 && r == 0, "R4 asleep wake request", w, 1);
      @(negedge clk); core_asleep = 1'b0;
      pulse_clr();
   endtask

   task automatic t_disabled();
      int cnt = 0;
      wr_opt(1'b0, 3'd0);
      pulse_clr();
      @(negedge clk); cfg_wd_en = 1'b0;
      repeat (BASE * 20) begin
         @(posedge clk); #1;
         if (rst_req || wake_req) cnt++;
      end
      chk(cnt == 0, "R8 no requests disabled", cnt, 0);
      chk(to_flag_n == 1, "R8 flag untouched", to_flag_n, 1);
      @(negedge clk); cfg_wd_en = 1'b1;
      pulse_clr();
   endtask

   task automatic t_timer_div(input logic [2:0] c);
      int cnt = 0;
      wr_opt(1'b1, 3'd0);
      wr_opt(1'b0, c);
      @(negedge clk); tmr_src_tick = 1'b1;
      for (int i = 0; i < 66; i++) begin
         @(posedge clk); #1;
         if (tmr_tick_out) cnt++;
         if (i == 63) tmr_src_tick = 1'b0;
      end
      chk(cnt == (64 >> (c + 1)), $sformatf("R9 timer divide code %0d", c), cnt, 64 >> (c + 1));
   endtask

   task automatic t_timer_pass();
      wr_opt(1'b1, 3'd4);
      @(negedge clk); tmr_src_tick = 1'b1;
      @(posedge clk); #1;
      chk(tmr_tick_out == 1, "R9 passthrough high", tmr_tick_out, 1);
      @(negedge clk); tmr_src_tick = 1'b0;
      @(posedge clk); #1;
      chk(tmr_tick_out == 0, "R9 passthrough low", tmr_tick_out, 0);
   endtask

   task automatic t_assign_change();
      int n; bit r, w;
      wr_opt(1'b1, 3'd2);
      pulse_clr();
      repeat (20) @(posedge clk);
      wr_opt(1'b0, 3'd2);
      measure(n, r, w);
      chk(n == BASE, "R10 select change restarts", n, BASE);
   endtask

   initial begin : watchdog_proc
      repeat (150000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog expired", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset_default();
      t_ratio(3'd0);
      t_ratio(3'd3);
      t_ratio(3'd7);
      t_undivided();
      t_clear_restart();
      t_sleep_wake();
      t_disabled();
      t_timer_div(3'd0);
      t_timer_div(3'd2);
      t_timer_pass();
      t_assign_change();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule